// File: doc/BRIEF.md
# Interrupt Indicator Bit Setter

This block turns a message-signalled interrupt write into two bit-set operations in memory. The written data word carries a vector number. The block sets one bit in a per-function indicator array and one bit in a summary array that several functions share. It raises an adapter interrupt only when the summary byte was entirely clear beforehand. Signals that arrive while a summary bit is already pending are therefore folded into the interrupt that is already outstanding.

Each bit is set by a locked read-modify-write of one byte through a byte-wide memory port. Bits are numbered from the most significant bit of each byte. A write is taken only while the function is enabled and the block is idle. A failing memory access posts a routing error event. A read of the notification region always returns all ones.

Top module: `msi_indicator_setter`

## Requirements
- R1: The vector number is the low VW bits of `msi_data`. The upper bits have no effect.
- R2: The indicator bit number is n = `ind_off` + vector. Its byte is at `ind_base` + n/8, and its mask is 8'h80 >> (n mod 8). The mask is ORed into the old byte, and all other bits of the byte are kept.
- R3: The summary bit follows the same address and mask rule, with n = `sum_off`.
- R4: The indicator byte is read and then written before the summary byte is read and then written. `mem_lock` stays high across all four accesses. Each write goes to the address that was just read.
- R5: `irq` is a one-cycle pulse carrying `irq_isc` = the latched `isc`. It fires only when the old summary byte read was 8'h00 and that byte was written back without error.
- R6: While `fn_enabled` is low, a write makes no memory access and does not raise `busy`.
- R7: `busy` is high from the cycle after an accepted write until both updates finish. A write that arrives while `busy` is high is ignored.
- R8: `notif_rd` yields `notif_rdata` of all ones in the next cycle.
- R9: An access acknowledged together with `mem_err` produces a one-cycle `err_evt` pulse. A failed indicator access still goes on to the summary update. A failed summary access suppresses `irq`.
- R10: After reset, `busy`, `mem_req`, `irq` and `err_evt` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| msi_wr | input | 1 | Notification write strobe |
| msi_data | input | DW | Written data word; the low bits are the vector |
| fn_enabled | input | 1 | Function is in the enabled state |
| ind_base | input | AW | Indicator array byte address |
| ind_off | input | OW | Indicator bit offset |
| sum_base | input | AW | Summary array byte address |
| sum_off | input | OW | Summary bit offset |
| isc | input | IW | Interrupt subclass |
| busy | output | 1 | Update in progress; new writes are refused |
| notif_rd | input | 1 | Notification region read strobe |
| notif_rdata | output | DW | Read data (all ones) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Locks memory for the read-modify-write sequence |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with the acknowledge |
| mem_ack | input | 1 | Access accepted |
| mem_err | input | 1 | Access failed, valid with the acknowledge |
| irq | output | 1 | Adapter interrupt pulse |
| irq_isc | output | IW | Subclass of the interrupt |
| err_evt | output | 1 | Routing error event pulse |

## Verification
With a memory that acknowledges at once, an accepted write produces four consecutive accesses starting the cycle after the strobe. `irq` or `err_evt` is registered on the edge that ends the access concerned, and `busy` falls on the edge after the last one. A stalling memory stretches this window by a variable number of cycles. For that reason the bench counts interrupt and error pulses and logs every acknowledged access at the clock edge. It compares memory, counts and logs only after `busy` has been seen low. The refused-write checks sample `busy` and the access count on the falling edge after the strobe. The notification read is checked one cycle after its strobe.

// File: rtl/msi_indicator_setter.sv
module msi_indicator_setter #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int VW = 11,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msi_wr,
  input  logic [DW-1:0] msi_data,
  input  logic          fn_enabled,
  input  logic [AW-1:0] ind_base,
  input  logic [OW-1:0] ind_off,
  input  logic [AW-1:0] sum_base,
  input  logic [OW-1:0] sum_off,
  input  logic [IW-1:0] isc,
  output logic          busy,
  input  logic          notif_rd,
  output logic [DW-1:0] notif_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_lock,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          irq,
  output logic [IW-1:0] irq_isc,
  output logic          err_evt
);
  localparam int NW = ((OW > VW) ? OW : VW) + 1;

  typedef enum logic [2:0] {S_IDLE, S_IRD, S_IWR, S_SRD, S_SWR} st_t;
  st_t st;

  logic [AW-1:0] ind_addr, sum_addr;
  logic [7:0]    ind_mask, sum_mask, old_q;
  logic [IW-1:0] isc_q;
  logic [NW-1:0] ind_bit, sum_bit;
  logic          accept;
  logic          unused_hi;

  assign unused_hi = ^msi_data[DW-1:VW];
  assign ind_bit = NW'(ind_off) + NW'(msi_data[VW-1:0]);
  assign sum_bit = NW'(sum_off);
  assign accept  = msi_wr && fn_enabled && (st == S_IDLE);

  assign busy      = (st != S_IDLE);
  assign mem_req   = busy;
  assign mem_lock  = busy;
  assign mem_we    = (st == S_IWR) || (st == S_SWR);
  assign mem_addr  = ((st == S_IRD) || (st == S_IWR)) ? ind_addr : sum_addr;
  assign mem_wdata = old_q | ((st == S_IWR) ? ind_mask : sum_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ind_addr    <= '0;
      sum_addr    <= '0;
      ind_mask    <= '0;
      sum_mask    <= '0;
      old_q       <= '0;
      isc_q       <= '0;
      irq         <= 1'b0;
      irq_isc     <= '0;
      err_evt     <= 1'b0;
      notif_rdata <= '0;
    end else begin
      irq         <= 1'b0;
      err_evt     <= 1'b0;
      notif_rdata <= notif_rd ? '1 : '0;
      case (st)
        S_IDLE: if (accept) begin
          ind_addr <= ind_base + AW'(ind_bit >> 3);
          ind_mask <= 8'h80 >> ind_bit[2:0];
          sum_addr <= sum_base + AW'(sum_bit >> 3);
          sum_mask <= 8'h80 >> sum_bit[2:0];
          isc_q    <= isc;
          st       <= S_IRD;
        end
        S_IRD: if (mem_ack) begin
          if (mem_err) begin
            err_evt <= 1'b1;
            st      <= S_SRD;
          end else begin
            old_q <= mem_rdata;
            st    <= S_IWR;
          end
        end
        S_IWR: if (mem_ack) begin
          if (mem_err) err_evt <= 1'b1;
          st <= S_SRD;
        end
        S_SRD: if (mem_ack) begin
          if (mem_err) begin
            err_evt <= 1'b1;
            st      <= S_IDLE;
          end else begin
            old_q <= mem_rdata;
            st    <= S_SWR;
          end
        end
        S_SWR: if (mem_ack) begin
          if (mem_err) err_evt <= 1'b1;
          else if (old_q == 8'h00) begin
            irq     <= 1'b1;
            irq_isc <= isc_q;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_req));
  assert_rmw_same_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && $past(mem_req && !mem_we)) |-> (mem_addr == $past(mem_addr)));
  assert_lock_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_after_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(mem_req && mem_we && mem_ack && !mem_err) && !busy));
  assert_disabled_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fn_enabled && !busy) |=> !busy);
  assert_notif_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    notif_rd |=> (&notif_rdata));
  assert_err_needs_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> $past(mem_ack && mem_err));
endmodule

// File: tb/tb_msi_indicator_setter.sv
module tb_msi_indicator_setter;
  localparam int DW = 32, AW = 32, OW = 16, VW = 11, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msi_wr = 1'b0, fn_enabled = 1'b1, notif_rd = 1'b0;
  logic [DW-1:0] msi_data = '0;
  logic [AW-1:0] ind_base = 32'h10, sum_base = 32'h40;
  logic [OW-1:0] ind_off = 16'd5, sum_off = 16'd10;
  logic [IW-1:0] isc = 3'd5;
  logic busy, mem_req, mem_we, mem_lock, mem_ack, mem_err, irq, err_evt;
  logic [DW-1:0] notif_rdata;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [IW-1:0] irq_isc;

  logic [7:0] mem [0:255];
  logic stall = 1'b0, ph = 1'b0;
  int irq_cnt = 0, err_cnt = 0, acc_cnt = 0, last_isc = 0;
  logic log_we [0:7];
  logic [7:0] log_addr [0:7];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  assign mem_ack   = mem_req && (!stall || ph);
  assign mem_err   = mem_ack && (mem_addr[7:4] == 4'hF);
  assign mem_rdata = mem[mem_addr[7:0]];

  msi_indicator_setter #(.DW(DW), .AW(AW), .OW(OW), .VW(VW), .IW(IW)) dut (
    .clk(clk), .rst_n(rst_n), .msi_wr(msi_wr), .msi_data(msi_data),
    .fn_enabled(fn_enabled), .ind_base(ind_base), .ind_off(ind_off),
    .sum_base(sum_base), .sum_off(sum_off), .isc(isc), .busy(busy),
    .notif_rd(notif_rd), .notif_rdata(notif_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .irq(irq), .irq_isc(irq_isc), .err_evt(err_evt));

  always @(posedge clk) begin
    ph <= ~ph;
    if (mem_req && mem_ack) begin
      if (acc_cnt < 8) begin
        log_we[acc_cnt]   <= mem_we;
        log_addr[acc_cnt] <= mem_addr[7:0];
      end
      acc_cnt <= acc_cnt + 1;
      if (mem_we && !mem_err) mem[mem_addr[7:0]] <= mem_wdata;
    end
    if (irq) begin
      irq_cnt  <= irq_cnt + 1;
      last_isc <= int'(irq_isc);
    end
    if (err_evt) err_cnt <= err_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic send(input logic [DW-1:0] d);
    @(negedge clk);
    msi_wr = 1'b1; msi_data = d;
    @(negedge clk);
    msi_wr = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 busy", busy, 0);
    chk("R10 mem_req", mem_req, 0);
    chk("R10 irq", irq, 0);
    chk("R10 err_evt", err_evt, 0);
  endtask

  task automatic t_basic();
    int i0 = irq_cnt;
    acc_cnt = 0;
    send(32'hABCD_F803);
    chk("R1 R2 indicator byte", mem[8'h11], 8'h80);
    chk("R3 summary byte", mem[8'h41], 8'h20);
    chk("R5 irq raised", irq_cnt - i0, 1);
    chk("R5 irq subclass", last_isc, 5);
    chk("R4 access count", acc_cnt, 4);
    chk("R4 order", {log_we[0], log_we[1], log_we[2], log_we[3]}, 4'b0101);
    chk("R4 addr ind rd", log_addr[0], 8'h11);
    chk("R4 addr ind wr", log_addr[1], 8'h11);
    chk("R4 addr sum rd", log_addr[2], 8'h41);
    chk("R4 addr sum wr", log_addr[3], 8'h41);
  endtask

  task automatic t_coalesce();
    int i0 = irq_cnt;
    send(32'd12);
    chk("R2 second indicator", mem[8'h12], 8'h40);
    chk("R5 summary unchanged", mem[8'h41], 8'h20);
    chk("R5 no irq when pending", irq_cnt - i0, 0);
  endtask

  task automatic t_preserve();
    int i0 = irq_cnt;
    mem[8'h13] = 8'h0F;
    mem[8'h41] = 8'h01;
    send(32'd21);
    chk("R2 keep other bits", mem[8'h13], 8'h2F);
    chk("R3 keep other bits", mem[8'h41], 8'h21);
    chk("R5 no irq, byte nonzero", irq_cnt - i0, 0);
  endtask

  task automatic t_disabled();
    int a0 = acc_cnt;
    fn_enabled = 1'b0;
    mem[8'h41] = 8'h00;
    @(negedge clk);
    msi_wr = 1'b1; msi_data = 32'd30;
    @(negedge clk);
    msi_wr = 1'b0;
    chk("R6 busy stays low", busy, 0);
    repeat (6) @(negedge clk);
    chk("R6 no access", acc_cnt - a0, 0);
    chk("R6 summary untouched", mem[8'h41], 8'h00);
    fn_enabled = 1'b1;
  endtask

  task automatic t_busy();
    int a0 = acc_cnt;
    clear_mem();
    stall = 1'b1;
    @(negedge clk);
    msi_wr = 1'b1; msi_data = 32'd3;
    @(negedge clk);
    chk("R7 busy after accept", busy, 1);
    msi_data = 32'd4;
    @(negedge clk);
    msi_wr = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R7 one update only", acc_cnt - a0, 4);
    chk("R7 first vector bit", mem[8'h11], 8'h80);
    stall = 1'b0;
  endtask

  task automatic t_notif();
    @(negedge clk);
    notif_rd = 1'b1;
    @(negedge clk);
    notif_rd = 1'b0;
    chk("R8 read all ones", notif_rdata, 32'hFFFF_FFFF);
  endtask

  task automatic t_error();
    int i0 = irq_cnt, e0 = err_cnt;
    clear_mem();
    ind_base = 32'hF0;
    send(32'd3);
    chk("R9 indicator error event", err_cnt - e0, 1);
    chk("R9 summary still set", mem[8'h41], 8'h20);
    chk("R9 irq after ind error", irq_cnt - i0, 1);
    ind_base = 32'h10;
    sum_base = 32'hF0;
    i0 = irq_cnt; e0 = err_cnt;
    send(32'd3);
    chk("R9 summary error event", err_cnt - e0, 1);
    chk("R9 irq suppressed", irq_cnt - i0, 0);
    chk("R9 indicator set", mem[8'h11], 8'h80);
    sum_base = 32'h40;
  endtask

  initial begin
    fork
      begin
        clear_mem();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_coalesce();
        t_preserve();
        t_disabled();
        t_busy();
        t_notif();
        t_error();
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule